// File: doc/BRIEF.md
# Complementary PWM Dead-Time Generator

This block drives three pairs of complementary PWM pins. Each pair has an output A and an output B. An external timer compares its 16-bit count against compare values and delivers set and clear events as one-cycle strobes, one set and one clear for every output. The block turns these strobes into request levels. It holds back each output while a per-output dead-time counter is running, and it keeps the two outputs of a pair from ever being active together.

Each output has a dead-time counter of its own. The counter loads that output's programmed length when the partner output goes inactive, and it counts down once per clock. An activation is granted only when the count has reached zero and the request is still held, so a request that ends during the dead interval is lost.

Two faults raise the error interrupt pulse:
- A pair whose two outputs would become active together. Both new activations are dropped. If one side was already active, that side is forced off and its falling edge starts the dead time of the other side.
- A rising match between the timer count and a dedicated check value. This forces every output off.

A single polarity input inverts all pins. The internal logic always works on active-high levels.

Top module: `cpwm_deadtime_top`

## Requirements
- R1: While reset is asserted, and after reset, every internal output is inactive, every dead-time counter is zero and `err_irq_o` is low. Each pin shows the inactive level, which is `pol_i`.
- R2: Pin `pin_o[2p]` is output A of pair p and `pin_o[2p+1]` is output B. A set strobe makes its output active at the next clock edge, provided the partner is inactive and the output's dead-time counter is zero. A clear strobe makes it inactive at the next edge. When set and clear arrive in the same cycle, clear wins.
- R3: When an output goes inactive at edge k, the partner's dead-time counter loads the partner's length D. Field p of `dt_a_i` is A's length and field p of `dt_b_i` is B's length. The partner cannot become active before edge k+D+1, and it does become active at that edge if its request is still held.
- R4: An activation requested while its dead-time counter is non-zero is ignored if its clear arrives before the counter reaches zero. When the dead time is at least as long as the requested active interval, the output stays inactive.
- R5: When both outputs of a pair would become active at the same edge, both stay inactive and both requests are dropped. `err_irq_o` is high for exactly the cycle after that edge.
- R6: When one output is active and its partner would become active, the active output is forced inactive, its request is dropped and `err_irq_o` pulses. The partner then becomes active after its dead time (R3).
- R7: When `cnt_i` first becomes equal to `chk_val_i`, all six outputs become inactive at that edge and all requests are dropped. `err_irq_o` pulses once. While the equality continues, no further pulse follows.
- R8: When `pol_i` is 1, every pin is the inverse of its internal active-high level. The effect is combinational and independent of the dead-time and overlap logic.
- R9: The two outputs of a pair are never active together.
- R10: The three pairs operate independently, each with its own dead-time lengths and counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cnt_i | input | 16 | Current timer count |
| chk_val_i | input | 16 | Error-check compare value |
| set_a_i | input | 3 | Set strobes for output A of each pair |
| clr_a_i | input | 3 | Clear strobes for output A of each pair |
| set_b_i | input | 3 | Set strobes for output B of each pair |
| clr_b_i | input | 3 | Clear strobes for output B of each pair |
| dt_a_i | input | 48 | Dead-time length of A per pair, in clocks (16 bits per pair) |
| dt_b_i | input | 48 | Dead-time length of B per pair, in clocks (16 bits per pair) |
| pol_i | input | 1 | 1 makes all pins active low |
| pin_o | output | 6 | Pin levels, A at even index, B at odd index |
| err_irq_o | output | 1 | One-cycle error interrupt pulse |

## Verification
A strobe or check match sampled before edge k changes the outputs and the error pulse right at edge k, through one register stage. A dead-time length of D therefore puts the partner's rise at edge k+D+1 after a fall at edge k. The bench drives inputs two nanoseconds after a rising edge and compares the outputs two nanoseconds after the next one. Every table row and directed step accounts for exactly one edge. Dead-time windows are checked at each edge in between, so a rise one cycle early or one cycle late is caught.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  localparam int unsigned NPAIR_DEF = 3;
  localparam int unsigned CW_DEF    = 16;
  localparam int unsigned DTW_DEF   = 16;

  typedef struct packed {
    logic set_a;
    logic clr_a;
    logic set_b;
    logic clr_b;
  } pair_strobe_t;
endpackage

// File: rtl/cpwm_dt_counter.sv
module cpwm_dt_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         idle_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = cnt_q;
    if (load_i)
      cnt_d = len_i;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/cpwm_match_edge.sv
module cpwm_match_edge #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt_i,
  input  logic [CW-1:0] val_i,
  output logic          evt_o
);
  logic hit, hit_q;

  assign hit = (cnt_i == val_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hit_q <= 1'b0;
    else
      hit_q <= hit;
  end

  assign evt_o = hit && !hit_q;
endmodule

// File: rtl/cpwm_pair.sv
module cpwm_pair
  import cpwm_pkg::*;
#(
  parameter int unsigned DTW = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  pair_strobe_t   stb_i,
  input  logic [DTW-1:0] dt_a_i,
  input  logic [DTW-1:0] dt_b_i,
  input  logic           kill_all_i,
  output logic           out_a_o,
  output logic           out_b_o,
  output logic           conflict_o
);
  logic req_a_q, req_b_q, req_a_d, req_b_d;
  logic out_a_q, out_b_q, out_a_d, out_b_d;
  logic req_a_raw, req_b_raw;
  logic idle_a, idle_b;
  logic act_a, act_b, conflict;
  logic kill_a, kill_b;
  logic fall_a, fall_b;

  // A activates only after B's fall; B only after A's fall
  cpwm_dt_counter #(.W(DTW)) u_dt_a (
    .clk(clk), .rst_n(rst_n), .load_i(fall_b), .len_i(dt_a_i), .idle_o(idle_a)
  );
  cpwm_dt_counter #(.W(DTW)) u_dt_b (
    .clk(clk), .rst_n(rst_n), .load_i(fall_a), .len_i(dt_b_i), .idle_o(idle_b)
  );

  always_comb begin
    req_a_raw = (req_a_q || stb_i.set_a) && !stb_i.clr_a;
    req_b_raw = (req_b_q || stb_i.set_b) && !stb_i.clr_b;
    act_a     = req_a_raw && idle_a;
    act_b     = req_b_raw && idle_b;
    conflict  = act_a && act_b;
    // on overlap drop whichever side is already on, or both if neither is
    kill_a    = kill_all_i || (conflict && !out_b_q);
    kill_b    = kill_all_i || (conflict && !out_a_q);
    req_a_d   = req_a_raw && !kill_a;
    req_b_d   = req_b_raw && !kill_b;
    out_a_d   = act_a && !out_b_q && !conflict && !kill_all_i;
    out_b_d   = act_b && !out_a_q && !conflict && !kill_all_i;
    fall_a    = out_a_q && !out_a_d;
    fall_b    = out_b_q && !out_b_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_a_q <= 1'b0;
      req_b_q <= 1'b0;
      out_a_q <= 1'b0;
      out_b_q <= 1'b0;
    end else begin
      req_a_q <= req_a_d;
      req_b_q <= req_b_d;
      out_a_q <= out_a_d;
      out_b_q <= out_b_d;
    end
  end

  assign out_a_o    = out_a_q;
  assign out_b_o    = out_b_q;
  assign conflict_o = conflict;
endmodule

// File: rtl/cpwm_deadtime_top.sv
module cpwm_deadtime_top
  import cpwm_pkg::*;
#(
  parameter int unsigned NPAIR = NPAIR_DEF,
  parameter int unsigned CW    = CW_DEF,
  parameter int unsigned DTW   = DTW_DEF
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        cnt_i,
  input  logic [CW-1:0]        chk_val_i,
  input  logic [NPAIR-1:0]     set_a_i,
  input  logic [NPAIR-1:0]     clr_a_i,
  input  logic [NPAIR-1:0]     set_b_i,
  input  logic [NPAIR-1:0]     clr_b_i,
  input  logic [NPAIR*DTW-1:0] dt_a_i,
  input  logic [NPAIR*DTW-1:0] dt_b_i,
  input  logic                 pol_i,
  output logic [2*NPAIR-1:0]   pin_o,
  output logic                 err_irq_o
);
  localparam int unsigned NPIN = 2 * NPAIR;

  logic             rst_meta_q, rst_sync_n;
  logic             chk_evt;
  logic [NPAIR-1:0] conflict;
  logic [NPIN-1:0]  act_lvl;
  logic             err_d, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cpwm_match_edge #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_sync_n), .cnt_i(cnt_i), .val_i(chk_val_i), .evt_o(chk_evt)
  );

  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    pair_strobe_t stb;
    assign stb = '{set_a: set_a_i[p], clr_a: clr_a_i[p],
                   set_b: set_b_i[p], clr_b: clr_b_i[p]};
    cpwm_pair #(.DTW(DTW)) u_pair (
      .clk        (clk),
      .rst_n      (rst_sync_n),
      .stb_i      (stb),
      .dt_a_i     (dt_a_i[p*DTW +: DTW]),
      .dt_b_i     (dt_b_i[p*DTW +: DTW]),
      .kill_all_i (chk_evt),
      .out_a_o    (act_lvl[2*p]),
      .out_b_o    (act_lvl[2*p+1]),
      .conflict_o (conflict[p])
    );
  end

  assign err_d = chk_evt || (|conflict);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)
      err_q <= 1'b0;
    else
      err_q <= err_d;
  end

  assign pin_o     = act_lvl ^ {NPIN{pol_i}};
  assign err_irq_o = err_q;
endmodule

// File: rtl/cpwm_deadtime_chk.sv
module cpwm_deadtime_chk #(
  parameter int unsigned NPAIR = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               pol_i,
  input logic [2*NPAIR-1:0] pin_o,
  input logic               err_irq_o
);
  logic [2*NPAIR-1:0] lvl;
  assign lvl = pin_o ^ {(2*NPAIR){pol_i}};

  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_idle: assert (lvl == '0 && !err_irq_o)
        else $error("R1: output active during reset");
    end
  end

  for (genvar p = 0; p < NPAIR; p++) begin : g_chk
    logic la, lb;
    assign la = lvl[2*p];
    assign lb = lvl[2*p+1];

    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(la && lb));
    a_r3_b_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lb) |-> !$past(la));
    a_r3_a_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(la) |-> !$past(lb));
    a_r3_fall_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(la) |-> !lb);
    a_r3_fall_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lb) |-> !la);
  end
endmodule

bind cpwm_deadtime_top cpwm_deadtime_chk #(.NPAIR(NPAIR)) u_cpwm_chk (
  .clk(clk), .rst_n(rst_n), .pol_i(pol_i), .pin_o(pin_o), .err_irq_o(err_irq_o)
);

// File: tb/test_cpwm_deadtime_top.sv
`timescale 1ns/1ps
module test_cpwm_deadtime_top;
  localparam int NP = 3;
  localparam int DW = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [15:0]     cnt, chk_val;
  logic [NP-1:0]   sa, ca, sb, cb;
  logic [NP*DW-1:0] dta, dtb;
  logic            pol;
  logic [2*NP-1:0] pin;
  logic            err;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  cpwm_deadtime_top i_cpwm_deadtime_top (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .chk_val_i(chk_val),
    .set_a_i(sa), .clr_a_i(ca), .set_b_i(sb), .clr_b_i(cb),
    .dt_a_i(dta), .dt_b_i(dtb), .pol_i(pol), .pin_o(pin), .err_irq_o(err)
  );

  // row: {set_a, clr_a, set_b, clr_b, exp_a, exp_b, exp_err}, pair 0, both lengths 2
  localparam int NV = 22;
  localparam logic [6:0] VEC [NV] = '{
    7'b0000_000, // R1 idle
    7'b1000_100, // R2 set A
    7'b0000_100,
    7'b0110_000, // R3 A falls, B waits
    7'b0000_000,
    7'b0000_000,
    7'b0000_010, // R3 B at k+3
    7'b0001_000, // B falls, A counter 2
    7'b1000_000, // R4 set A during dead time
    7'b0100_000, // R4 cleared before expiry
    7'b0000_000,
    7'b0000_000,
    7'b1010_001, // R5 both at once
    7'b0000_000,
    7'b1000_100,
    7'b0010_001, // R6 B while A on
    7'b0000_000,
    7'b0000_000,
    7'b0000_010, // R6 B after dead time
    7'b0001_000,
    7'b0000_000,
    7'b0000_000
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
    sa = '0; ca = '0; sb = '0; cb = '0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    sa = '0; ca = '0; sb = '0; cb = '0;
    cnt = 16'h0000; chk_val = 16'h1234; pol = 1'b0;
    dta = {3{16'd2}}; dtb = {3{16'd2}};
    repeat (3) @(posedge clk);
    #2;
    check("R1 pins in reset", pin, 6'h00);
    check("R1 err in reset", err, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check("R1 pins after reset", pin, 6'h00);

    for (int i = 0; i < NV; i++) begin
      sa[0] = VEC[i][6]; ca[0] = VEC[i][5]; sb[0] = VEC[i][4]; cb[0] = VEC[i][3];
      step();
      check($sformatf("R2-table row %0d A", i), pin[0], VEC[i][2]);
      check($sformatf("R3-table row %0d B", i), pin[1], VEC[i][1]);
      check($sformatf("R5 R6 table row %0d err", i), err, VEC[i][0]);
    end

    // R2 clear beats set in the same cycle
    sa[1] = 1'b1; ca[1] = 1'b1;
    step();
    check("R2 clear priority", pin[2], 1'b0);

    // R8 polarity inversion
    pol = 1'b1;
    #1;
    check("R8 idle pins inverted", pin, 6'h3F);
    sa[0] = 1'b1;
    step();
    check("R8 active pin low", pin, 6'h3E);
    ca[0] = 1'b1;
    step();
    pol = 1'b0;
    #1;
    check("R8 restored", pin, 6'h00);

    // R7 check-value match
    sa[1] = 1'b1;
    step();
    check("R7 pre A1 active", pin[2], 1'b1);
    cnt = 16'h1234;
    step();
    check("R7 outputs forced off", pin, 6'h00);
    check("R7 err pulse", err, 1'b1);
    step();
    check("R7 single pulse", err, 1'b0);
    check("R7 request dropped", pin[2], 1'b0);
    cnt = 16'h0001;
    step();

    // R10 pair 2 with B length 5, other pairs untouched
    dtb[2*DW +: DW] = 16'd5;
    repeat (4) step();
    sa[2] = 1'b1;
    step();
    check("R10 A2 active", pin, 6'h10);
    ca[2] = 1'b1; sb[2] = 1'b1;
    step();
    check("R10 A2 off", pin, 6'h00);
    for (int k = 1; k <= 5; k++) begin
      step();
      check($sformatf("R10 B2 held at k+%0d", k), pin[5], 1'b0);
    end
    step();
    check("R10 B2 rises at k+6", pin, 6'h20);

    finish_run();
  end
endmodule